// File: doc/BRIEF.md
# Ternary CAM Search Engine

This block is a small ternary content-addressable memory driven by a command bus. It holds `ENTRIES` entries. Each entry has a 68-bit data word and a 68-bit mask word. A command strobe qualifies a 9-bit command word. The two low bits of that word choose one of four operations: read an array word, write an array word, search the table for a key, or learn a key into the first free slot. The upper bits carry parameters. Bit 2 is the only parameter used here, and it picks the mask array or the data array for reads and writes.

A search presents a key on the shared input data bus. The key is compared with every occupied entry, and a compare is skipped for each bit position whose mask bit is cleared. A lowest-index-first encoder resolves the case where several entries match. Bit 0 of every data word is the entry's occupancy flag. Learn uses this flag to find a slot, and the full flag is the AND of all occupancy flags. Reads return their word one cycle after the command, together with a one-cycle acknowledge.

Top module: `tcam_engine`

## Requirements
- R1: Operation codes sit in cmd[1:0]: 2'b00 read, 2'b01 write, 2'b10 search, 2'b11 learn. A command is accepted only in a cycle where cmd_valid is 1. In any other cycle the command bus has no effect.
- R2: For a read, dq_in[IDXW-1:0] is the entry index and cmd[2] selects the array (0 data, 1 mask). One cycle later ack is 1 for exactly one cycle and dq_out holds the selected word. In all other cycles ack and dq_out are 0.
- R3: For a write, dq_in carries the entry index in the command cycle and the word in the next cycle. cmd[2] selects the array as for reads. Any command presented in that second cycle is ignored.
- R4: An entry takes part in a search only when bit 0 of its data word is 1. It matches when every key bit whose mask bit is 1 equals the stored data bit. Key bits whose mask bit is 0 do not affect the result.
- R5: One cycle after a search command, hit_valid is 1 for exactly one cycle. hit and hit_index are updated at the same time and hold their values until the next search.
- R6: When several entries match, hit_index is the lowest matching index. On a miss, hit is 0 and hit_index is 0.
- R7: Learn stores the key, with bit 0 forced to 1, into the lowest-index entry whose bit 0 is 0. It also sets that entry's mask to all ones.
- R8: A learn issued while full is 1 changes no entry.
- R9: full is 1 exactly when bit 0 of every data word is 1. It reflects a write or learn in the cycle after the command's final cycle.
- R10: Reset clears every data and mask word, so every entry is empty. It also clears ack, dq_out, hit_valid, hit, hit_index and full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Qualifies the command bus |
| cmd | input | 9 | Operation in [1:0], array select in [2] |
| dq_in | input | WIDTH | Index, write word or search/learn key |
| dq_out | output | WIDTH | Read word, zero outside a read response |
| ack | output | 1 | One-cycle marker for valid read data |
| hit_valid | output | 1 | One-cycle marker for a search result |
| hit | output | 1 | Last search found a match |
| hit_index | output | IDXW | Lowest matching index of the last search |
| full | output | 1 | Every entry is occupied |

## Verification
The table is first filled by learning sixteen distinct keys. Each key is then searched, which shows that every slot is addressed independently and that full rises only with the last slot. Next, one entry's mask is opened to accept almost any key, so a search for a higher entry's key shows that the priority encoder picks the lower index. An exhaustive sweep runs every 4-bit mask pattern against every 4-bit key nibble on entry 0. It separates mask-1 compare from mask-0 don't-care bit by bit, and it also exercises falling through to later entries on a miss. Clearing one occupancy bit shows the removed entry dropping out of searches and being refilled by learn. Further cases cover learns into a full table, commands without the strobe, and commands presented during a write's data cycle.

// File: rtl/tcam_engine.sv
module tcam_engine #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 68,
  parameter int IDXW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [8:0]       cmd,
  input  logic [WIDTH-1:0] dq_in,
  output logic [WIDTH-1:0] dq_out,
  output logic             ack,
  output logic             hit_valid,
  output logic             hit,
  output logic [IDXW-1:0]  hit_index,
  output logic             full
);
  localparam logic [1:0] OP_RD = 2'b00;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_SR = 2'b10;
  localparam logic [1:0] OP_LN = 2'b11;

  logic [WIDTH-1:0] dat_q [ENTRIES];
  logic [WIDTH-1:0] msk_q [ENTRIES];
  logic             wr_pend_q, wr_sel_q;
  logic [IDXW-1:0]  wr_addr_q;
  logic [ENTRIES-1:0] used, match;
  logic             any_hit, any_free;
  logic [IDXW-1:0]  hit_idx, free_idx;
  logic [WIDTH-1:0] rd_word;

  wire             take = cmd_valid && !wr_pend_q;
  wire [1:0]       op   = cmd[1:0];
  wire             sel  = cmd[2];
  wire [IDXW-1:0]  addr = dq_in[IDXW-1:0];
  wire             in_range = 32'(addr) < ENTRIES;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign used[g]  = dat_q[g][0];
    assign match[g] = used[g] && (((dq_in ^ dat_q[g]) & msk_q[g]) == '0);
  end

  assign full = &used;

  always_comb begin
    any_hit  = 1'b0;
    hit_idx  = '0;
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        any_hit = 1'b1;
        hit_idx = IDXW'(i);
      end
      if (!used[i]) begin
        any_free = 1'b1;
        free_idx = IDXW'(i);
      end
    end
  end

  assign rd_word = !in_range ? '0 : (sel ? msk_q[addr] : dat_q[addr]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        dat_q[i] <= '0;
        msk_q[i] <= '0;
      end
    end else if (wr_pend_q) begin
      if (32'(wr_addr_q) < ENTRIES) begin
        if (wr_sel_q) msk_q[wr_addr_q] <= dq_in;
        else          dat_q[wr_addr_q] <= dq_in;
      end
    end else if (take && op == OP_LN && any_free) begin
      dat_q[free_idx] <= dq_in | WIDTH'(1);
      msk_q[free_idx] <= '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pend_q <= 1'b0;
      wr_sel_q  <= 1'b0;
      wr_addr_q <= '0;
      ack       <= 1'b0;
      dq_out    <= '0;
      hit_valid <= 1'b0;
      hit       <= 1'b0;
      hit_index <= '0;
    end else begin
      wr_pend_q <= take && op == OP_WR;
      if (take && op == OP_WR) begin
        wr_sel_q  <= sel;
        wr_addr_q <= addr;
      end
      ack       <= take && op == OP_RD;
      dq_out    <= (take && op == OP_RD) ? rd_word : '0;
      hit_valid <= take && op == OP_SR;
      if (take && op == OP_SR) begin
        hit       <= any_hit;
        hit_index <= any_hit ? hit_idx : '0;
      end
    end
  end
endmodule

module tcam_engine_chk #(
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [8:0]      cmd,
  input logic            ack,
  input logic            hit_valid,
  input logic            hit,
  input logic [IDXW-1:0] hit_index,
  input logic            full,
  input logic            wr_pend
);
  a_r2_ack_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(cmd_valid && cmd[1:0] == 2'b00 && !wr_pend));

  a_r1_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!ack && !hit_valid));

  a_r5_result_after_search: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> $past(cmd_valid && cmd[1:0] == 2'b10 && !wr_pend));

  a_r3_data_cycle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> (!ack && !hit_valid && !wr_pend));

  a_r6_miss_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit) |-> hit_index == '0);

  a_r8_full_learn_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && cmd_valid && cmd[1:0] == 2'b11 && !wr_pend) |=> full);

  a_r10_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!ack && !hit_valid && !full));
endmodule

bind tcam_engine tcam_engine_chk #(.IDXW(IDXW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .ack(ack),
  .hit_valid(hit_valid), .hit(hit), .hit_index(hit_index), .full(full),
  .wr_pend(wr_pend_q)
);

// File: tb/tcam_engine_tb_top.sv
`timescale 1ns/1ps
module tcam_engine_tb_top;
  localparam int N = 16;
  localparam int W = 68;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [8:0] cmd = '0;
  logic [W-1:0] dq_in = '0;
  logic [W-1:0] dq_out;
  logic ack, hit_valid, hit, full;
  logic [IW-1:0] hit_index;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] md [N];
  logic [W-1:0] mm [N];

  always #2.5 clk = ~clk;

  tcam_engine #(.ENTRIES(N), .WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .dq_in(dq_in),
    .dq_out(dq_out), .ack(ack), .hit_valid(hit_valid), .hit(hit),
    .hit_index(hit_index), .full(full));

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] key_of(input int i);
    return {4'h9, 32'(i * 32'h9E37_79B9), 28'(i * 28'h0ABC_DE1), 4'(i) | 4'h1};
  endfunction

  function automatic bit m_full();
    for (int i = 0; i < N; i++) if (!md[i][0]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int m_search(input logic [W-1:0] k);
    for (int i = 0; i < N; i++)
      if (md[i][0] && (((k ^ md[i]) & mm[i]) == '0)) return i;
    return -1;
  endfunction

  task automatic wr(input bit s, input int a, input logic [W-1:0] w);
    @(negedge clk); cmd_valid = 1'b1; cmd = {6'd0, s, 2'b01}; dq_in = W'(a);
    @(negedge clk); cmd_valid = 1'b0; dq_in = w;
    if (s) mm[a] = w; else md[a] = w;
  endtask

  task automatic rd(input bit s, input int a, input string req);
    logic [W-1:0] e;
    e = s ? mm[a] : md[a];
    @(negedge clk); cmd_valid = 1'b1; cmd = {6'd0, s, 2'b00}; dq_in = W'(a);
    @(negedge clk); cmd_valid = 1'b0;
    chk(ack === 1'b1, {req, " ack"}, W'(ack), W'(1));
    chk(dq_out === e, req, dq_out, e);
  endtask

  task automatic srch(input logic [W-1:0] k, input string req);
    int e;
    e = m_search(k);
    @(negedge clk); cmd_valid = 1'b1; cmd = 9'b10; dq_in = k;
    @(negedge clk); cmd_valid = 1'b0;
    chk(hit_valid === 1'b1 && hit === (e >= 0), {req, " hit"}, W'(hit), W'(e >= 0));
    chk(hit_index === IW'(e >= 0 ? e : 0), {req, " index"}, W'(hit_index), W'(e >= 0 ? e : 0));
  endtask

  task automatic lrn(input logic [W-1:0] k, input string req);
    @(negedge clk); cmd_valid = 1'b1; cmd = 9'b11; dq_in = k;
    if (!m_full()) begin
      for (int i = 0; i < N; i++) if (!md[i][0]) begin
        md[i] = k | W'(1); mm[i] = '1; break;
      end
    end
    @(negedge clk); cmd_valid = 1'b0;
    chk(full === m_full(), {req, " full"}, W'(full), W'(m_full()));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin md[i] = '0; mm[i] = '0; end
    repeat (3) @(negedge clk);
    chk(ack === 0 && hit_valid === 0 && full === 0 && dq_out === '0, "R10 reset outputs",
        {ack, hit_valid, full}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, 5, "R10 data cleared");
    rd(1'b1, 5, "R10 mask cleared");

    // R1: commands without strobe do nothing
    cmd_valid = 1'b0; cmd = 9'b00; dq_in = '0;
    @(negedge clk); @(negedge clk);
    chk(ack === 0 && dq_out === '0, "R1 read without strobe", W'(ack), 0);
    cmd = 9'b11; dq_in = key_of(1);
    @(negedge clk); @(negedge clk);
    rd(1'b0, 0, "R1 learn without strobe");
    cmd = 9'b10;
    @(negedge clk);
    chk(hit_valid === 0, "R1 search without strobe", W'(hit_valid), 0);

    // R7 R9: fill by learn
    for (int i = 0; i < N; i++) begin
      lrn(key_of(i), "R9 learn fill");
      rd(1'b0, i, "R7 learned data");
      rd(1'b1, i, "R7 learned mask");
    end
    @(negedge clk);
    chk(ack === 0 && dq_out === '0, "R2 ack single cycle", W'(ack), 0);

    // R8: learn while full
    lrn(key_of(77), "R8 learn full");
    for (int i = 0; i < N; i++) rd(1'b0, i, "R8 table unchanged");
    srch(key_of(77), "R8 unlearned key misses");

    // R5: find each key
    for (int i = 0; i < N; i++) srch(key_of(i), "R5 search each");
    @(negedge clk);
    chk(hit_valid === 0, "R5 hit_valid single cycle", W'(hit_valid), 0);
    chk(hit === 1 && hit_index === IW'(N - 1), "R5 result held", W'(hit_index), W'(N - 1));

    // R6: open entry 10 mask, search key of entry 12
    wr(1'b1, 10, W'(1));
    srch(key_of(12), "R6 lowest index wins");
    srch(key_of(5), "R6 lower entry first");
    srch(key_of(12) & ~W'(1), "R4 bit0 key mismatch");

    // R3: command in data cycle ignored
    @(negedge clk); cmd_valid = 1'b1; cmd = 9'b01; dq_in = W'(3);
    @(negedge clk); cmd = 9'b10; dq_in = key_of(40);
    md[3] = key_of(40);
    @(negedge clk); cmd_valid = 1'b0;
    chk(hit_valid === 0, "R3 search in data cycle ignored", W'(hit_valid), 0);
    rd(1'b0, 3, "R3 written word");

    // R9 R4 R7: clear occupancy of entry 2
    wr(1'b0, 2, key_of(2) & ~W'(1));
    @(negedge clk);
    chk(full === 0, "R9 full drops", W'(full), 0);
    srch(key_of(2), "R4 empty entry skipped");
    lrn(key_of(50), "R7 refill empty");
    rd(1'b0, 2, "R7 refilled slot");

    // R4: exhaustive mask x nibble sweep on entry 0
    wr(1'b0, 0, {63'h0, 4'b1010, 1'b1});
    for (int m = 0; m < 16; m++) begin
      wr(1'b1, 0, {63'h0, 4'(m), 1'b1});
      for (int k = 0; k < 16; k++)
        srch({63'h2F0F_1234_5678_ABCD, 4'(k), 1'b1}, "R4 ternary sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule